// File: doc/BRIEF.md
# Disk Task-File Access Filter

This block stands between a byte-addressed I/O bus and the task-file register sets of two disk channels. Each channel has two windows. The eight-byte command window holds the byte-wide task-file registers and, at its base offset, the wide data port. The four-byte control window holds one register, the alternate-status / device-control register. For every access the filter checks the window, the offset and the access width together. A legal access goes on as a single-cycle strobe to the register file or to the data port. An illegal access is dropped: a dropped read returns an all-ones value as wide as the access, and a dropped write changes nothing.

A request is taken in the cycle that `req_valid` is high and registered once. In the next cycle the filter drives the strobes, together with the register index and the write data. In that same cycle it returns the read response, built combinationally from the read data that the register file or data port offers. A new request can be accepted every cycle. Bus data is little-endian and right-justified: byte 0 of an access is on bits 7:0.

Top module: `tff_filter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every strobe and `rsp_valid` are 0. Asserting `rst_n` clears strobes that are active.
- R2: On the command window (`req_win`=0), a 1-byte access (`req_size`=0) at offset k raises the matching read or write register strobe of the selected channel with `tf_idx`=k for exactly one cycle, in the cycle after the request.
- R3: On the control window (`req_win`=1), only a 1-byte access at offset 2 is forwarded, as a register strobe with `tf_idx`=8.
- R4: Every other control-window access raises no strobe. As a read it returns all ones of the access width.
- R5: On the command window, a 2-byte (`req_size`=1) or 4-byte (`req_size`=2) access at offset 0 raises a data-port strobe. `dp_wide` is 1 only for the 4-byte width. A 2-byte write carries `req_wdata[15:0]` on `dp_wdata[15:0]` with zero above, and a 2-byte read returns `dp_rdata[15:0]` zero-extended.
- R6: A 2-byte or 4-byte command-window access at a nonzero offset raises no strobe. As a read it returns 0x0000FFFF or 0xFFFFFFFF.
- R7: `req_size`=3 is reserved. Such an access is always dropped, and as a read it returns 0xFFFFFFFF.
- R8: A forwarded 1-byte read returns the register byte on bits 7:0 with the upper 24 bits zero. A 1-byte dropped read returns 0x000000FF.
- R9: Strobes appear only on the channel given by `req_chan`, at most one strobe bit is high in any cycle, and read data is taken from that channel.
- R10: A read produces `rsp_valid`=1 in the strobe cycle, whether it was forwarded or dropped. A write never raises `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 1 | 0 = command window, 1 = control window |
| req_chan | input | CHW | Channel index |
| req_off | input | 3 | Byte offset inside the window |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Right-justified read data |
| tf_rd_stb | output | NUM_CH | Per-channel register read strobe |
| tf_wr_stb | output | NUM_CH | Per-channel register write strobe |
| tf_idx | output | 4 | Register index (0..7 command window, 8 control register) |
| tf_wdata | output | 8 | Register write byte |
| tf_rdata | input | NUM_CH*8 | Register read byte per channel, for the current index |
| dp_rd_stb | output | NUM_CH | Per-channel data-port read strobe |
| dp_wr_stb | output | NUM_CH | Per-channel data-port write strobe |
| dp_wide | output | 1 | 1 = 32-bit data-port transfer, 0 = 16-bit |
| dp_wdata | output | 32 | Data-port write data |
| dp_rdata | input | NUM_CH*32 | Data-port read data per channel |

## Verification
Two functions share a cycle when requests arrive back to back. The strobe and response of one access go out in the same cycle that the next access is decoded and captured. The stub also commits a forwarded write on the very edge that captures the following read of the same register. The stimulus table is walked with `req_valid` held high throughout, alternating channels, windows, and legal and dropped accesses. Each cycle is judged on its own: one strobe on the right channel, or none at all, and a response equal to what the stub holds after every earlier write.

// File: rtl/tff_pkg.sv
package tff_pkg;

  localparam int BUS_W      = 32;
  localparam int DWIN_BYTES = 8;
  localparam int CWIN_BYTES = 4;
  localparam int CTRL_OFF   = 2;
  localparam int OFF_W      = $clog2(DWIN_BYTES);
  localparam int TF_IDX_W   = OFF_W + 1;
  localparam int CTRL_IDX   = DWIN_BYTES;

  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_RSV = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RT_DROP = 2'd0,
    RT_REG  = 2'd1,
    RT_PORT = 2'd2
  } route_e;

  typedef struct packed {
    logic                valid;
    logic                write;
    route_e              route;
    logic [TF_IDX_W-1:0] idx;
    acc_size_e           size;
    logic [BUS_W-1:0]    wdata;
  } acc_t;

endpackage

// File: rtl/tff_decode.sv
module tff_decode
  import tff_pkg::*;
(
  input  logic                win,
  input  logic [OFF_W-1:0]    off,
  input  acc_size_e           size,
  output route_e              route,
  output logic [TF_IDX_W-1:0] idx
);

  localparam logic [OFF_W-1:0]    CTRL_OFF_V = OFF_W'(CTRL_OFF);
  localparam logic [TF_IDX_W-1:0] CTRL_IDX_V = TF_IDX_W'(CTRL_IDX);

  logic is_wide;

  always_comb begin
    is_wide = (size == SZ_B2) || (size == SZ_B4);
    route   = RT_DROP;
    idx     = '0;
    if (!win) begin
      if (size == SZ_B1) begin
        route = RT_REG;
        idx   = TF_IDX_W'(off);
      end else if (is_wide && (off == '0)) begin
        route = RT_PORT;
      end
    end else if ((size == SZ_B1) && (off == CTRL_OFF_V)) begin
      route = RT_REG;
      idx   = CTRL_IDX_V;
    end
  end

endmodule

// File: rtl/tff_stage.sv
module tff_stage
  import tff_pkg::*;
#(
  parameter int CHW = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [CHW-1:0]      req_chan,
  input  acc_size_e           req_size,
  input  logic [BUS_W-1:0]    req_wdata,
  input  route_e              dec_route,
  input  logic [TF_IDX_W-1:0] dec_idx,
  output acc_t                cur,
  output logic [CHW-1:0]      cur_chan
);

  acc_t           nxt;
  logic [CHW-1:0] nxt_chan;
  logic           en;

  always_comb begin
    nxt      = cur;
    nxt_chan = cur_chan;
    en       = req_valid | cur.valid;
    if (req_valid) begin
      nxt.valid = 1'b1;
      nxt.write = req_write;
      nxt.route = dec_route;
      nxt.idx   = dec_idx;
      nxt.size  = req_size;
      nxt.wdata = req_wdata;
      nxt_chan  = req_chan;
    end else begin
      nxt.valid = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '0;
      cur_chan <= '0;
    end else if (en) begin
      cur      <= nxt;
      cur_chan <= nxt_chan;
    end
  end

endmodule

// File: rtl/tff_fanout.sv
module tff_fanout
  import tff_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CHW    = 1
) (
  input  acc_t              cur,
  input  logic [CHW-1:0]    cur_chan,
  output logic [NUM_CH-1:0] tf_rd_stb,
  output logic [NUM_CH-1:0] tf_wr_stb,
  output logic [NUM_CH-1:0] dp_rd_stb,
  output logic [NUM_CH-1:0] dp_wr_stb
);

  logic go_reg, go_port;

  always_comb begin
    go_reg  = cur.valid && (cur.route == RT_REG);
    go_port = cur.valid && (cur.route == RT_PORT);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    always_comb begin
      hit          = (cur_chan == CHW'(c));
      tf_rd_stb[c] = go_reg  && hit && !cur.write;
      tf_wr_stb[c] = go_reg  && hit &&  cur.write;
      dp_rd_stb[c] = go_port && hit && !cur.write;
      dp_wr_stb[c] = go_port && hit &&  cur.write;
    end
  end

endmodule

// File: rtl/tff_resp.sv
module tff_resp
  import tff_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CHW    = 1
) (
  input  acc_t                    cur,
  input  logic [CHW-1:0]          cur_chan,
  input  logic [NUM_CH*8-1:0]     tf_rdata,
  input  logic [NUM_CH*BUS_W-1:0] dp_rdata,
  output logic                    rsp_valid,
  output logic [BUS_W-1:0]        rsp_rdata
);

  function automatic logic [BUS_W-1:0] ones_for(acc_size_e s);
    case (s)
      SZ_B1:   ones_for = BUS_W'(8'hFF);
      SZ_B2:   ones_for = BUS_W'(16'hFFFF);
      default: ones_for = '1;
    endcase
  endfunction

  logic [7:0]       reg_byte;
  logic [BUS_W-1:0] port_word;

  always_comb begin
    reg_byte  = tf_rdata[int'(cur_chan)*8 +: 8];
    port_word = dp_rdata[int'(cur_chan)*BUS_W +: BUS_W];
    rsp_valid = cur.valid && !cur.write;
    case (cur.route)
      RT_REG:  rsp_rdata = BUS_W'(reg_byte);
      RT_PORT: rsp_rdata = (cur.size == SZ_B4) ? port_word : BUS_W'(port_word[15:0]);
      default: rsp_rdata = ones_for(cur.size);
    endcase
  end

endmodule

// File: rtl/tff_filter.sv
module tff_filter
  import tff_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_win,
  input  logic [CHW-1:0]          req_chan,
  input  logic [OFF_W-1:0]        req_off,
  input  logic [1:0]              req_size,
  input  logic [BUS_W-1:0]        req_wdata,
  output logic                    rsp_valid,
  output logic [BUS_W-1:0]        rsp_rdata,
  output logic [NUM_CH-1:0]       tf_rd_stb,
  output logic [NUM_CH-1:0]       tf_wr_stb,
  output logic [TF_IDX_W-1:0]     tf_idx,
  output logic [7:0]              tf_wdata,
  input  logic [NUM_CH*8-1:0]     tf_rdata,
  output logic [NUM_CH-1:0]       dp_rd_stb,
  output logic [NUM_CH-1:0]       dp_wr_stb,
  output logic                    dp_wide,
  output logic [BUS_W-1:0]        dp_wdata,
  input  logic [NUM_CH*BUS_W-1:0] dp_rdata
);

  acc_size_e           size_in;
  route_e              dec_route;
  logic [TF_IDX_W-1:0] dec_idx;
  acc_t                cur;
  logic [CHW-1:0]      cur_chan;

  assign size_in = acc_size_e'(req_size);

  tff_decode u_decode (
    .win   (req_win),
    .off   (req_off),
    .size  (size_in),
    .route (dec_route),
    .idx   (dec_idx)
  );

  tff_stage #(.CHW(CHW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_chan  (req_chan),
    .req_size  (size_in),
    .req_wdata (req_wdata),
    .dec_route (dec_route),
    .dec_idx   (dec_idx),
    .cur       (cur),
    .cur_chan  (cur_chan)
  );

  tff_fanout #(.NUM_CH(NUM_CH), .CHW(CHW)) u_fanout (
    .cur       (cur),
    .cur_chan  (cur_chan),
    .tf_rd_stb (tf_rd_stb),
    .tf_wr_stb (tf_wr_stb),
    .dp_rd_stb (dp_rd_stb),
    .dp_wr_stb (dp_wr_stb)
  );

  tff_resp #(.NUM_CH(NUM_CH), .CHW(CHW)) u_resp (
    .cur       (cur),
    .cur_chan  (cur_chan),
    .tf_rdata  (tf_rdata),
    .dp_rdata  (dp_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  always_comb begin
    tf_idx   = cur.idx;
    tf_wdata = cur.wdata[7:0];
    dp_wide  = (cur.route == RT_PORT) && (cur.size == SZ_B4);
    dp_wdata = dp_wide ? cur.wdata : BUS_W'(cur.wdata[15:0]);
  end

  logic any_stb;
  assign any_stb = |{tf_rd_stb, tf_wr_stb, dp_rd_stb, dp_wr_stb};

  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tf_rd_stb, tf_wr_stb, dp_rd_stb, dp_wr_stb}));

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> $past(req_valid));

  // R4
  ctrl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_win && !((req_off == OFF_W'(CTRL_OFF)) && (req_size == 2'd0)))
      |=> !any_stb);

  // R6
  wide_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_win && (req_size != 2'd0) && (req_off != '0)) |=> !any_stb);

  // R5
  port_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|{dp_rd_stb, dp_wr_stb}) |-> ($past(req_off) == '0 && !$past(req_win)));

  // R10
  rsp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

endmodule

// File: tb/tff_filter_tb_top.sv
`timescale 1ns/1ps
module tff_filter_tb_top;

  localparam int NCH = 2;
  localparam int NV  = 22;

  typedef struct packed {
    logic [7:0]  rq;
    logic        chan;
    logic        win;
    logic        wr;
    logic [2:0]  off;
    logic [1:0]  sz;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        fwd;
  } vec_t;

  // columns: req tag, chan, win, write, off, size, wdata, expected read, forwarded
  localparam vec_t VEC [NV] = '{
    '{8'd2,  1'b0, 1'b0, 1'b0, 3'd3, 2'd0, 32'h0,        32'h00000033, 1'b1}, // R2
    '{8'd9,  1'b1, 1'b0, 1'b0, 3'd5, 2'd0, 32'h0,        32'h00000055, 1'b1}, // R9
    '{8'd3,  1'b0, 1'b1, 1'b0, 3'd2, 2'd0, 32'h0,        32'h00000038, 1'b1}, // R3
    '{8'd3,  1'b1, 1'b1, 1'b0, 3'd2, 2'd0, 32'h0,        32'h00000058, 1'b1}, // R3
    '{8'd5,  1'b0, 1'b0, 1'b0, 3'd0, 2'd1, 32'h0,        32'h00003344, 1'b1}, // R5
    '{8'd5,  1'b1, 1'b0, 1'b0, 3'd0, 2'd2, 32'h0,        32'hA1B2C3D4, 1'b1}, // R5
    '{8'd6,  1'b0, 1'b0, 1'b0, 3'd2, 2'd1, 32'h0,        32'h0000FFFF, 1'b0}, // R6
    '{8'd6,  1'b1, 1'b0, 1'b0, 3'd4, 2'd2, 32'h0,        32'hFFFFFFFF, 1'b0}, // R6
    '{8'd8,  1'b0, 1'b1, 1'b0, 3'd0, 2'd0, 32'h0,        32'h000000FF, 1'b0}, // R8
    '{8'd4,  1'b0, 1'b1, 1'b0, 3'd2, 2'd1, 32'h0,        32'h0000FFFF, 1'b0}, // R4
    '{8'd4,  1'b1, 1'b1, 1'b0, 3'd3, 2'd2, 32'h0,        32'hFFFFFFFF, 1'b0}, // R4
    '{8'd2,  1'b0, 1'b0, 1'b1, 3'd6, 2'd0, 32'h0000009C, 32'h0,        1'b1}, // R2
    '{8'd2,  1'b0, 1'b0, 1'b0, 3'd6, 2'd0, 32'h0,        32'h0000009C, 1'b1}, // R2
    '{8'd4,  1'b1, 1'b1, 1'b1, 3'd1, 2'd0, 32'h00000077, 32'h0,        1'b0}, // R4
    '{8'd4,  1'b1, 1'b1, 1'b0, 3'd2, 2'd0, 32'h0,        32'h00000058, 1'b1}, // R4
    '{8'd4,  1'b1, 1'b0, 1'b0, 3'd1, 2'd0, 32'h0,        32'h00000051, 1'b1}, // R4
    '{8'd5,  1'b0, 1'b0, 1'b1, 3'd0, 2'd1, 32'hDEADBEEF, 32'h0,        1'b1}, // R5
    '{8'd5,  1'b0, 1'b0, 1'b0, 3'd0, 2'd2, 32'h0,        32'h1122BEEF, 1'b1}, // R5
    '{8'd6,  1'b1, 1'b0, 1'b1, 3'd4, 2'd1, 32'h00001234, 32'h0,        1'b0}, // R6
    '{8'd6,  1'b1, 1'b0, 1'b0, 3'd0, 2'd2, 32'h0,        32'hA1B2C3D4, 1'b1}, // R6
    '{8'd6,  1'b1, 1'b0, 1'b0, 3'd4, 2'd0, 32'h0,        32'h00000054, 1'b1}, // R6
    '{8'd7,  1'b0, 1'b0, 1'b0, 3'd0, 2'd3, 32'h0,        32'hFFFFFFFF, 1'b0}  // R7
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid, req_write, req_win;
  logic [0:0]      req_chan;
  logic [2:0]      req_off;
  logic [1:0]      req_size;
  logic [31:0]     req_wdata;
  logic            rsp_valid;
  logic [31:0]     rsp_rdata;
  logic [NCH-1:0]  tf_rd_stb, tf_wr_stb, dp_rd_stb, dp_wr_stb;
  logic [3:0]      tf_idx;
  logic [7:0]      tf_wdata;
  logic [NCH*8-1:0]  tf_rdata;
  logic            dp_wide;
  logic [31:0]     dp_wdata;
  logic [NCH*32-1:0] dp_rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tff_filter #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_win(req_win), .req_chan(req_chan), .req_off(req_off), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .tf_rd_stb(tf_rd_stb), .tf_wr_stb(tf_wr_stb), .tf_idx(tf_idx), .tf_wdata(tf_wdata),
    .tf_rdata(tf_rdata), .dp_rd_stb(dp_rd_stb), .dp_wr_stb(dp_wr_stb), .dp_wide(dp_wide),
    .dp_wdata(dp_wdata), .dp_rdata(dp_rdata)
  );

  // register-file and data-port stub
  logic [7:0]  tfreg [NCH][9];
  logic [31:0] dpreg [NCH];

  initial begin
    for (int c = 0; c < NCH; c++) begin
      for (int i = 0; i < 9; i++) tfreg[c][i] = 8'h30 + 8'(c * 32) + 8'(i);
    end
    dpreg[0] = 32'h11223344;
    dpreg[1] = 32'hA1B2C3D4;
  end

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (tf_wr_stb[c] && tf_idx < 4'd9) tfreg[c][tf_idx] <= tf_wdata;
      if (dp_wr_stb[c]) dpreg[c] <= dp_wide ? dp_wdata : {dpreg[c][31:16], dp_wdata[15:0]};
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      tf_rdata[c*8 +: 8]   = (tf_idx < 4'd9) ? tfreg[c][tf_idx] : 8'h00;
      dp_rdata[c*32 +: 32] = dpreg[c];
    end
  end

  function automatic logic [NCH-1:0] stb_any();
    return tf_rd_stb | tf_wr_stb | dp_rd_stb | dp_wr_stb;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_vec(input int i);
    vec_t v = VEC[i];
    string tag = $sformatf("R%0d vec%0d", v.rq, i);
    logic [NCH-1:0] want = v.fwd ? NCH'(1) << v.chan : '0;
    check({tag, " strobes"}, 32'(stb_any()), 32'(want));
    check({tag, " rsp_valid"}, 32'(rsp_valid), 32'(!v.wr));
    if (!v.wr) check({tag, " rdata"}, rsp_rdata, v.exp);
  endtask

  task automatic drive(input vec_t v);
    req_valid = 1'b1; req_chan = v.chan; req_win = v.win; req_write = v.wr;
    req_off = v.off; req_size = v.sz; req_wdata = v.wdata;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0; req_win = 1'b0; req_chan = '0;
    req_off = '0; req_size = '0; req_wdata = '0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: held in reset
    check("R1 stb in reset", 32'(stb_any()), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stb after release", 32'(stb_any()), 32'h0);
    check("R1 rsp_valid after release", 32'(rsp_valid), 32'h0);

    // back-to-back walk of the table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check_vec(i);
    end
    idle();
    @(negedge clk);
    // R2: strobe lasts one cycle only
    check("R2 strobe drops after idle", 32'(stb_any()), 32'h0);

    // R10: dropped write gives no response, R8 data byte on low lane
    drive('{8'd10, 1'b0, 1'b1, 1'b1, 3'd0, 2'd0, 32'h0, 32'h0, 1'b0});
    @(negedge clk);
    idle();
    check("R10 dropped write rsp", 32'(rsp_valid), 32'h0);
    check("R10 dropped write stb", 32'(stb_any()), 32'h0);

    // R1: reset clears an active strobe
    drive('{8'd1, 1'b1, 1'b0, 1'b0, 3'd7, 2'd0, 32'h0, 32'h0, 1'b1});
    @(posedge clk);
    #1;
    idle();
    check("R8 byte read lane", rsp_rdata, 32'h00000057);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", 32'(stb_any()), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      finish_run();
    end
  end

endmodule